// File: doc/BRIEF.md
# MDIO Management Master with Register Access

This block lets a processor manage Ethernet PHYs over a two-wire management bus (clause 22 framing). Software sees six word registers on a simple request bus: a configuration register, a command register, a PHY/register address register, a write-data register, a read-result register and a busy flag. A write to the write-data register sends a write frame. Setting the read bit of the command register sends a read frame, and the 16 bits the PHY returns land in the read-result register.

The management clock is produced from the system clock only while a frame runs. A 4-bit index in the configuration register selects its period from a fixed table of even divisors. A soft-reset bit in the same register aborts a frame in flight and holds the bus quiet until software clears it. While a frame runs, register writes are dropped, with one exception: the soft-reset bit.

Top module: `mdio_regs_master`

## Requirements
- R1: After rst_ni is released, the busy register reads 0, mdc_o is low, mdio_oe_o is low, and the configuration and read-result registers read 0.
- R2: Writing offset 3 (write data, bits 15:0) while idle sends a 64-bit write frame with every bit driven, MSB first: 32 ones, 01, opcode 01, PHY address (address register bits 12:8), register number (address register bits 4:0 only), turnaround 10, then the written 16-bit value.
- R3: Writing offset 1 (command) with bit 0 set while idle sends a read frame of 32 ones, 01, opcode 10, PHY address and register number. mdio_oe_o is low from bit 46 (the turnaround) through bit 63 and whenever the master is idle.
- R4: When a read frame ends, offset 4 (read result) bits 15:0 hold the 16 bits sampled from mdio_i on the rising MDC edges of frame bits 48 to 63, first sample in bit 15.
- R5: Offset 5 (busy) reads 1 from the cycle after a frame is launched until the frame ends, and reads 0 otherwise.
- R6: Each MDC period is table[idx] system clocks, where idx is configuration bits 3:0 and the table is 4,4,6,8,10,14,20,28,34,42,50,58,66,74,82,98, half high and half low. MDC is low while idle.
- R7: While a frame runs, the driven MDIO value changes only on a falling MDC edge.
- R8: Setting configuration bit 8 (soft reset) aborts any frame, so that busy reads 0, MDC is low and MDIO is released. While the bit is set, no frame starts. Clearing it lets frames run again.
- R9: While busy, writes to the command, address and write-data registers and to the divider index are ignored and start nothing. Only configuration bit 8 still updates.
- R10: Writing the command register with bit 0 clear starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access valid |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register offset (0 cfg, 1 cmd, 2 addr, 3 wdata, 4 result, 5 busy) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
On every cycle the assertions check that MDC and the MDIO driver stay quiet while idle and that driven data moves only on a falling MDC edge. They also check that a set soft-reset bit forces idle on the next cycle and that the address and write-data registers hold still through a frame. Only the bench scenarios can show the frame contents bit by bit, the read-result value, the MDC period measured for several divider indices, and that dropped writes left no trace, which is seen by reading the registers back and counting MDC edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_AW     = 3;
  localparam int REG_DW     = 16;
  localparam int PHY_W      = 5;
  localparam int PHY_SHIFT  = 8;
  localparam int REGN_W     = 5;
  localparam int REGN_HOLD  = 8;
  localparam int DATA_W     = 16;
  localparam int FRAME_LEN  = 64;
  localparam int RELEASE_AT = 46;
  localparam int RX_FIRST   = FRAME_LEN - DATA_W;
  localparam int DIV_IDX_W  = 4;
  localparam int DIV_W      = 7;
  localparam int CFG_RST    = 8;

  typedef enum logic [REG_AW-1:0] {
    OFF_CFG    = 3'd0,
    OFF_CMD    = 3'd1,
    OFF_ADDR   = 3'd2,
    OFF_WDATA  = 3'd3,
    OFF_RESULT = 3'd4,
    OFF_BUSY   = 3'd5
  } reg_off_e;

  function automatic logic [DIV_W-1:0] div_lookup(input logic [DIV_IDX_W-1:0] idx);
    case (idx)
      4'd0:    div_lookup = 7'd4;
      4'd1:    div_lookup = 7'd4;
      4'd2:    div_lookup = 7'd6;
      4'd3:    div_lookup = 7'd8;
      4'd4:    div_lookup = 7'd10;
      4'd5:    div_lookup = 7'd14;
      4'd6:    div_lookup = 7'd20;
      4'd7:    div_lookup = 7'd28;
      4'd8:    div_lookup = 7'd34;
      4'd9:    div_lookup = 7'd42;
      4'd10:   div_lookup = 7'd50;
      4'd11:   div_lookup = 7'd58;
      4'd12:   div_lookup = 7'd66;
      4'd13:   div_lookup = 7'd74;
      4'd14:   div_lookup = 7'd82;
      default: div_lookup = 7'd98;
    endcase
  endfunction

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic              is_read,
    input logic [PHY_W-1:0]  phy,
    input logic [REGN_W-1:0] regn,
    input logic [DATA_W-1:0] data
  );
    if (is_read)
      build_frame = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, regn, 2'b11, {DATA_W{1'b1}}};
    else
      build_frame = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, regn, 2'b10, data};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv
  import mdio_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic [DIV_IDX_W-1:0] idx_i,
  output logic                 tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_m1;

  assign half_m1 = (div_lookup(idx_i) >> 1) - DIV_W'(1);
  assign tick_o  = run_i && (cnt_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int LEN     = FRAME_LEN,
  parameter int RX_W    = DATA_W,
  parameter int RX_AT   = RX_FIRST,
  parameter int FREE_AT = RELEASE_AT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            is_read_i,
  input  logic [LEN-1:0]  frame_i,
  input  logic            abort_i,
  input  logic            tick_i,
  input  logic            mdio_i,
  output logic            busy_o,
  output logic            mdc_o,
  output logic            mdio_o,
  output logic            mdio_oe_o,
  output logic            rd_done_o,
  output logic [RX_W-1:0] rd_data_o
);
  localparam int BIT_W = $clog2(LEN);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(LEN - 1);

  logic             busy_q, mdc_q, rd_q;
  logic [BIT_W-1:0] bit_q;
  logic [LEN-1:0]   sh_q;
  logic [RX_W-1:0]  cap_q;

  assign busy_o    = busy_q;
  assign mdc_o     = mdc_q;
  assign mdio_o    = sh_q[LEN-1];
  assign mdio_oe_o = busy_q && (!rd_q || (bit_q < BIT_W'(FREE_AT)));
  assign rd_done_o = busy_q && tick_i && mdc_q && (bit_q == LAST) && rd_q && !abort_i;
  assign rd_data_o = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
      rd_q   <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      mdc_q  <= 1'b0;
      rd_q   <= is_read_i;
      bit_q  <= '0;
      sh_q   <= frame_i;
    end else if (busy_q && tick_i) begin
      if (!mdc_q) begin
        mdc_q <= 1'b1;
        if (rd_q && bit_q >= BIT_W'(RX_AT)) cap_q <= {cap_q[RX_W-2:0], mdio_i};
      end else begin
        mdc_q <= 1'b0;
        if (bit_q == LAST) begin
          busy_q <= 1'b0;
        end else begin
          bit_q <= bit_q + BIT_W'(1);
          sh_q  <= {sh_q[LEN-2:0], 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regs_master.sv
module mdio_regs_master
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic [DIV_IDX_W-1:0] div_idx_q;
  logic                 cfg_rst_q;
  logic                 cmd_rd_q;
  logic [PHY_W-1:0]     phy_q;
  logic [REGN_HOLD-1:0] regn_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [DATA_W-1:0]    result_q;

  logic busy, tick, rd_done, wr, wr_idle, start_rd, start_wr;
  logic [DATA_W-1:0]    rd_data;
  logic [FRAME_LEN-1:0] frame;

  assign wr       = reg_req_i && reg_we_i;
  assign wr_idle  = wr && !busy;
  assign start_rd = wr_idle && (reg_addr_i == OFF_CMD) && reg_wdata_i[0] && !cfg_rst_q;
  assign start_wr = wr_idle && (reg_addr_i == OFF_WDATA) && !cfg_rst_q;
  assign frame    = build_frame(start_rd, phy_q, regn_q[REGN_W-1:0], reg_wdata_i[DATA_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_idx_q <= '0;
      cfg_rst_q <= 1'b0;
      cmd_rd_q  <= 1'b0;
      phy_q     <= '0;
      regn_q    <= '0;
      wdata_q   <= '0;
      result_q  <= '0;
    end else begin
      if (wr && reg_addr_i == OFF_CFG) begin
        cfg_rst_q <= reg_wdata_i[CFG_RST];
        if (!busy) div_idx_q <= reg_wdata_i[DIV_IDX_W-1:0];
      end
      if (wr_idle && reg_addr_i == OFF_CMD) cmd_rd_q <= reg_wdata_i[0];
      if (wr_idle && reg_addr_i == OFF_ADDR) begin
        phy_q  <= reg_wdata_i[PHY_SHIFT +: PHY_W];
        regn_q <= reg_wdata_i[REGN_HOLD-1:0];
      end
      if (wr_idle && reg_addr_i == OFF_WDATA) wdata_q <= reg_wdata_i[DATA_W-1:0];
      if (rd_done) result_q <= rd_data;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFF_CFG: begin
        reg_rdata_o[CFG_RST]         = cfg_rst_q;
        reg_rdata_o[DIV_IDX_W-1:0]   = div_idx_q;
      end
      OFF_CMD:    reg_rdata_o[0] = cmd_rd_q;
      OFF_ADDR: begin
        reg_rdata_o[PHY_SHIFT +: PHY_W] = phy_q;
        reg_rdata_o[REGN_HOLD-1:0]      = regn_q;
      end
      OFF_WDATA:  reg_rdata_o[DATA_W-1:0] = wdata_q;
      OFF_RESULT: reg_rdata_o[DATA_W-1:0] = result_q;
      OFF_BUSY:   reg_rdata_o[0] = busy;
      default:    reg_rdata_o = '0;
    endcase
  end

  mdio_clkdiv u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy && !cfg_rst_q),
    .idx_i  (div_idx_q),
    .tick_o (tick)
  );

  mdio_frame_engine u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_rd || start_wr),
    .is_read_i (start_rd),
    .frame_i   (frame),
    .abort_i   (cfg_rst_q),
    .tick_i    (tick),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rd_done_o (rd_done),
    .rd_data_o (rd_data)
  );
endmodule

// File: rtl/mdio_regs_master_chk.sv
module mdio_regs_master_chk
  import mdio_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 busy_i,
  input logic                 mdc_i,
  input logic                 mdio_i,
  input logic                 mdio_oe_i,
  input logic                 cfg_rst_i,
  input logic [PHY_W-1:0]     phy_i,
  input logic [REGN_HOLD-1:0] regn_i,
  input logic [DATA_W-1:0]    wdata_i
);
  AST_IDLE_MDC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_i); // R6

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdio_oe_i); // R3

  AST_MDIO_FALL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && !$fell(mdc_i)) |-> $stable(mdio_i)); // R7

  AST_SOFT_RST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rst_i |=> (!busy_i && !mdc_i)); // R8

  AST_BUSY_HOLDS_REGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(phy_i) && $stable(regn_i) && $stable(wdata_i))); // R9
endmodule

bind mdio_regs_master mdio_regs_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy),
  .mdc_i     (mdc_o),
  .mdio_i    (mdio_o),
  .mdio_oe_i (mdio_oe_o),
  .cfg_rst_i (cfg_rst_q),
  .phy_i     (phy_q),
  .regn_i    (regn_q),
  .wdata_i   (wdata_q)
);

// File: tb/mdio_regs_master_bench.sv
`timescale 1ns/1ps
module mdio_regs_master_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_req_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = 3'd0;
  logic [15:0] reg_wdata_i = 16'd0;
  logic [15:0] reg_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int nbit = 0;
  time t_prev = 0, t_last = 0;
  logic [63:0] cap_bits = '0, cap_oe = '0;
  logic [15:0] resp = 16'h0;

  mdio_regs_master u_mdio_regs_master (.*);

  always #2 clk_i = ~clk_i;

  always @(posedge mdc_o) begin
    if (nbit < 64) begin
      cap_bits[63-nbit] = mdio_o;
      cap_oe[63-nbit]   = mdio_oe_o;
    end
    nbit++;
    t_prev = t_last;
    t_last = $time;
  end

  always @(negedge mdc_o)
    mdio_i = (nbit >= 48 && nbit < 64) ? resp[63-nbit] : 1'b1;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_req_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_we_i = 1'b0; reg_req_i = 1'b1;
    #0.5 d = reg_rdata_o;
    reg_req_i = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 20000; i++) begin
      reg_rd(3'd5, v);
      if (v == 16'd0) break;
    end
  endtask

  function automatic logic [63:0] exp_wr(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d};
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    reg_rd(3'd5, v); chk(v == 0, "R1 busy", v, 0);
    chk(mdc_o == 0, "R1 mdc", mdc_o, 0);
    chk(mdio_oe_o == 0, "R1 oe", mdio_oe_o, 0);
    reg_rd(3'd0, v); chk(v == 0, "R1 cfg", v, 0);
    reg_rd(3'd4, v); chk(v == 0, "R1 result", v, 0);
  endtask

  task automatic t_write(input logic [3:0] idx, input int div, input logic [4:0] phy,
                         input logic [7:0] rg, input logic [15:0] d);
    logic [15:0] v;
    reg_wr(3'd0, {12'd0, idx});
    reg_wr(3'd2, {3'd0, phy, rg});
    nbit = 0;
    reg_wr(3'd3, d);
    reg_rd(3'd5, v); chk(v == 1, "R5 busy during write", v, 1);
    wait_idle();
    chk(cap_bits == exp_wr(phy, rg[4:0], d), "R2 write frame", cap_bits, exp_wr(phy, rg[4:0], d));
    chk(cap_oe == '1, "R2 write all driven", cap_oe, '1);
    chk((t_last - t_prev) == div * 4, "R6 mdc period", (t_last - t_prev) / 4, div);
    chk(nbit == 64, "R2 edge count", nbit, 64);
  endtask

  task automatic t_read(input logic [3:0] idx, input int div, input logic [4:0] phy,
                        input logic [7:0] rg, input logic [15:0] r);
    logic [15:0] v;
    logic [45:0] e;
    e = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg[4:0]};
    resp = r;
    reg_wr(3'd0, {12'd0, idx});
    reg_wr(3'd1, 16'd0);
    reg_wr(3'd2, {3'd0, phy, rg});
    nbit = 0;
    reg_wr(3'd1, 16'd1);
    reg_rd(3'd5, v); chk(v == 1, "R5 busy during read", v, 1);
    wait_idle();
    chk(cap_bits[63:18] == e, "R3 read header", cap_bits[63:18], e);
    chk(cap_oe == {{46{1'b1}}, 18'd0}, "R3 release at turnaround", cap_oe, {{46{1'b1}}, 18'd0});
    reg_rd(3'd4, v); chk(v == r, "R4 read result", v, r);
    chk((t_last - t_prev) == div * 4, "R6 mdc period read", (t_last - t_prev) / 4, div);
    reg_wr(3'd1, 16'd0);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] v;
    reg_wr(3'd0, 16'd0);
    reg_wr(3'd1, 16'd0);
    reg_wr(3'd2, 16'h0A12);
    nbit = 0;
    reg_wr(3'd3, 16'h1234);
    reg_wr(3'd2, 16'h1F0F);
    reg_wr(3'd3, 16'hFFFF);
    reg_wr(3'd1, 16'd1);
    reg_wr(3'd0, 16'd5);
    wait_idle();
    repeat (20) @(negedge clk_i);
    reg_rd(3'd2, v); chk(v == 16'h0A12, "R9 addr kept", v, 16'h0A12);
    reg_rd(3'd3, v); chk(v == 16'h1234, "R9 wdata kept", v, 16'h1234);
    reg_rd(3'd1, v); chk(v == 16'd0, "R9 cmd kept", v, 0);
    reg_rd(3'd0, v); chk(v == 16'd0, "R9 cfg idx kept", v, 0);
    reg_rd(3'd5, v); chk(v == 16'd0, "R9 no extra frame", v, 0);
    chk(nbit == 64, "R9 single frame", nbit, 64);
    chk(cap_bits == exp_wr(5'h0A, 5'h12, 16'h1234), "R9 frame content", cap_bits, exp_wr(5'h0A, 5'h12, 16'h1234));
  endtask

  task automatic t_cmd_clear();
    logic [15:0] v;
    nbit = 0;
    reg_wr(3'd1, 16'd0);
    repeat (30) @(negedge clk_i);
    reg_rd(3'd5, v); chk(v == 16'd0, "R10 no frame busy", v, 0);
    chk(nbit == 0, "R10 no mdc edges", nbit, 0);
  endtask

  task automatic t_soft_reset();
    logic [15:0] v;
    reg_wr(3'd0, 16'd0);
    reg_wr(3'd2, 16'h0305);
    reg_wr(3'd3, 16'hBEEF);
    repeat (40) @(negedge clk_i);
    reg_wr(3'd0, 16'h0100);
    reg_rd(3'd5, v); chk(v == 16'd0, "R8 abort busy", v, 0);
    chk(mdc_o == 0, "R8 mdc low", mdc_o, 0);
    chk(mdio_oe_o == 0, "R8 released", mdio_oe_o, 0);
    nbit = 0;
    reg_wr(3'd3, 16'h4321);
    repeat (20) @(negedge clk_i);
    reg_rd(3'd5, v); chk(v == 16'd0, "R8 no start in reset", v, 0);
    chk(nbit == 0, "R8 no mdc in reset", nbit, 0);
    reg_wr(3'd0, 16'd0);
    nbit = 0;
    reg_wr(3'd3, 16'h5AA5);
    wait_idle();
    chk(cap_bits == exp_wr(5'h03, 5'h05, 16'h5AA5), "R8 resume frame", cap_bits, exp_wr(5'h03, 5'h05, 16'h5AA5));
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_write(4'd0, 4, 5'h13, 8'hE5, 16'hA55A);
    t_read(4'd3, 8, 5'h0A, 8'h1F, 16'hC3A5);
    t_read(4'd15, 98, 5'h01, 8'h02, 16'h8001);
    t_write(4'd6, 20, 5'h1F, 8'h00, 16'h0000);
    t_write(4'd1, 4, 5'h00, 8'h1F, 16'hFFFF);
    t_busy_ignore();
    t_cmd_clear();
    t_soft_reset();
    summary();
    $finish;
  end
endmodule